// File: doc/BRIEF.md
# Interrupt register stacking sequencer

This block saves part of the integer register file to the stack when an interrupt is taken, and restores it when the handler returns. The registers are grouped into ranges. The ranges are cumulative, so enabling a range means that every lower range is enabled as well. The number of ranges present is fixed when the block is built.

On entry the sequencer reads the stack pointer. It then reads each register to be saved through a combinational register-file read port and issues one word store per stack slot on a simple request/ready memory port. After the stores it lowers the stack pointer by the full frame and writes the interrupted pc into the return-address register. Finally it marks the new nesting level in a status vector and pulses a vector-fetch request. On return it reverses the sequence: it loads the same slots back into the register file, raises the stack pointer, clears the status bit and pulses a jump to the return target.

Only the deepest nesting level can save fewer ranges than are implemented. A 2-bit control input selects how many. The stack frame size does not change with this choice.

Top module: `irq_stack_seq`

## Requirements
- R1: After reset, busy, mem_req and rf_we are low and every nest_status bit is 0.
- R2: On entry, slot k (k = 0,1,2,...) is stored to address old_sp − (k+1)·XLEN/8. The slot order is x1, x10, x11, reserved, x12, x13, x14, x15, x4, x5, x6, x7, x16, x17, x28, x29, x30, x31. Only one access is in flight at a time: mem_req, mem_we and mem_addr hold until mem_ready. busy stays high from acceptance until the final cycle of the sequence.
- R3: The reserved slot (slot 3) is stored as zero on entry. On return it is loaded, but it is never written to the register file.
- R4: At nesting levels 1 to 3, all implemented ranges are saved. The frame is 4, 8 or 12 words for 1, 2 or 3 ranges, and 18 words for 4 ranges. The number of ranges is NUM_RANGES, from 2 to 4.
- R5: At nesting level 4, lvl4_ranges selects the saved ranges: 00 saves range 0, 01 saves ranges 0–1, 10 saves ranges 0–2 and 11 saves ranges 0–3. A value above NUM_RANGES−1 is treated as NUM_RANGES−1. Registers outside the saved set are left untouched by the return.
- R6: Entry lowers sp (x2) by the full implemented frame, and return raises it by the same amount, even when level 4 saves fewer ranges.
- R7: After the stores, entry writes ra (x1) with irq_pc OR 1. In the next cycle it pulses vec_fetch for one cycle and sets nest_status bit (level−1).
- R8: Return loads the slots of the level being left, from the same addresses they were stored to. It then clears the highest set nest_status bit and pulses jump_valid for one cycle, with jump_target equal to the ret_target that was sampled.
- R9: Once an entry is accepted, dropping irq_req does not stop it. The whole entry still completes.
- R10: A return request while no level is active pulses nmi_unrec for one cycle and makes no memory access and no register write.
- R11: An entry request while all four levels are active is ignored: busy stays low and nest_status stays the same.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | 1 | Interrupt entry request, sampled while idle |
| irq_pc | input | XLEN | Interrupted pc, sampled with irq_req |
| ret_req | input | 1 | Interrupt return request, sampled while idle |
| ret_target | input | XLEN | Return jump address, sampled with ret_req |
| lvl4_ranges | input | 2 | Range selection for the fourth nesting level |
| rf_raddr | output | 5 | Register file read address |
| rf_rdata | input | XLEN | Register file read data (same cycle) |
| rf_we | output | 1 | Register file write enable |
| rf_waddr | output | 5 | Register file write address |
| rf_wdata | output | XLEN | Register file write data |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = store, 0 = load |
| mem_addr | output | XLEN | Byte address of the access |
| mem_wdata | output | XLEN | Store data |
| mem_rdata | input | XLEN | Load data, valid with mem_ready |
| mem_ready | input | 1 | Access completes in this cycle |
| busy | output | 1 | A save or restore sequence is running |
| nest_status | output | 4 | One bit per active nesting level |
| vec_fetch | output | 1 | One-cycle vector fetch request |
| jump_valid | output | 1 | One-cycle return jump strobe |
| jump_target | output | XLEN | Return jump address |
| nmi_unrec | output | 1 | One-cycle unrecoverable-return NMI request |

## Verification
Several properties are checked on every cycle:
- a pending access holds its request, direction and address until ready;
- the status vector stays a contiguous run of set bits from level 1;
- no level is set when full or cleared when empty;
- the latched slot count never exceeds the frame;
- vec_fetch always follows the ra write;
- nmi_unrec only appears while idle.

The bench scenarios are needed for the rest:
- the slot order, addresses and data;
- the zeroed reserved slot and that it is not written back;
- the stack pointer arithmetic across four nested frames;
- level-4 trimming and the clamping of an out-of-range selection;
- registers outside a trimmed frame surviving the return;
- completion after a dropped request;
- the exact cycle count under memory wait states.

// File: rtl/irq_stack_pkg.sv
package irq_stack_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_E_SP,
    ST_E_ST,
    ST_E_SPW,
    ST_E_RA,
    ST_E_VEC,
    ST_X_SP,
    ST_X_LD,
    ST_X_SPW,
    ST_X_DONE
  } seq_state_e;

  localparam int unsigned SLOT_W = 5;
  localparam logic [4:0]  REG_RA = 5'd1;
  localparam logic [4:0]  REG_SP = 5'd2;
  localparam logic [4:0]  RSVD_SLOT = 5'd3;

  // Register held in each stack slot; the reserved slot maps to x0.
  function automatic logic [4:0] slot_to_reg(input logic [4:0] idx);
    logic [4:0] r;
    case (idx)
      5'd0:    r = 5'd1;
      5'd1:    r = 5'd10;
      5'd2:    r = 5'd11;
      5'd3:    r = 5'd0;
      5'd4:    r = 5'd12;
      5'd5:    r = 5'd13;
      5'd6:    r = 5'd14;
      5'd7:    r = 5'd15;
      5'd8:    r = 5'd4;
      5'd9:    r = 5'd5;
      5'd10:   r = 5'd6;
      5'd11:   r = 5'd7;
      5'd12:   r = 5'd16;
      5'd13:   r = 5'd17;
      5'd14:   r = 5'd28;
      5'd15:   r = 5'd29;
      5'd16:   r = 5'd30;
      5'd17:   r = 5'd31;
      default: r = 5'd0;
    endcase
    return r;
  endfunction

  // Cumulative word count when ranges 0..top are present.
  function automatic logic [4:0] ranges_to_words(input logic [1:0] top);
    logic [4:0] w;
    case (top)
      2'd0:    w = 5'd4;
      2'd1:    w = 5'd8;
      2'd2:    w = 5'd12;
      default: w = 5'd18;
    endcase
    return w;
  endfunction

endpackage

// File: rtl/irq_slot_map.sv
module irq_slot_map
  import irq_stack_pkg::*;
#(
  parameter int unsigned NUM_RANGES = 3
) (
  input  logic [4:0] slot_idx,
  input  logic       trim,
  input  logic [1:0] lvl4_ranges,
  output logic [4:0] slot_reg,
  output logic       slot_rsvd,
  output logic [4:0] slot_count,
  output logic [4:0] frame_words
);

  localparam logic [1:0] TOP_RANGE = 2'(NUM_RANGES - 1);

  logic [1:0] legal_sel;

  generate
    if (NUM_RANGES >= 4) begin : g_full
      assign legal_sel = lvl4_ranges;
    end else begin : g_clamp
      assign legal_sel = (lvl4_ranges > TOP_RANGE) ? TOP_RANGE : lvl4_ranges;
    end
  endgenerate

  assign frame_words = ranges_to_words(TOP_RANGE);
  assign slot_count  = trim ? ranges_to_words(legal_sel) : frame_words;
  assign slot_reg    = slot_to_reg(slot_idx);
  assign slot_rsvd   = (slot_idx == RSVD_SLOT);

endmodule

// File: rtl/irq_nest_tracker.sv
module irq_nest_tracker #(
  parameter int unsigned NEST_LEVELS = 4,
  localparam int unsigned DEPTH_W = $clog2(NEST_LEVELS + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   nest_set,
  input  logic                   nest_clr,
  output logic [NEST_LEVELS-1:0] status,
  output logic [DEPTH_W-1:0]     depth
);

  logic [NEST_LEVELS-1:0] status_q, status_d;
  logic                   status_en;

  always_comb begin
    status_d  = status_q;
    status_en = nest_set | nest_clr;
    if (nest_set) begin
      status_d = {status_q[NEST_LEVELS-2:0], 1'b1};
    end else if (nest_clr) begin
      status_d = {1'b0, status_q[NEST_LEVELS-1:1]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
    end else if (status_en) begin
      status_q <= status_d;
    end
  end

  always_comb begin
    depth = '0;
    for (int i = 0; i < NEST_LEVELS; i++) begin
      depth = depth + DEPTH_W'(status_q[i]);
    end
  end

  assign status = status_q;

  // R8: active levels always form a contiguous run from level 1
  a_r8_status_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    ((status_q & (status_q + 1'b1)) == '0));

  // R11: no level is added once all are active
  a_r11_no_set_when_full: assert property (@(posedge clk) disable iff (!rst_n)
    nest_set |-> (depth < DEPTH_W'(NEST_LEVELS)));

  // R10: nothing is cleared when no level is active
  a_r10_no_clr_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    nest_clr |-> (depth != '0));

endmodule

// File: rtl/irq_stack_fsm.sv
module irq_stack_fsm
  import irq_stack_pkg::*;
#(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NEST_LEVELS = 4,
  localparam int unsigned DEPTH_W = $clog2(NEST_LEVELS + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               irq_req,
  input  logic [XLEN-1:0]    irq_pc,
  input  logic               ret_req,
  input  logic [XLEN-1:0]    ret_target,
  input  logic [DEPTH_W-1:0] depth,
  input  logic [4:0]         slot_reg,
  input  logic               slot_rsvd,
  input  logic [4:0]         slot_count,
  input  logic [4:0]         frame_words,
  output logic               map_trim,
  output logic [4:0]         slot_idx,
  output logic [4:0]         rf_raddr,
  input  logic [XLEN-1:0]    rf_rdata,
  output logic               rf_we,
  output logic [4:0]         rf_waddr,
  output logic [XLEN-1:0]    rf_wdata,
  output logic               mem_req,
  output logic               mem_we,
  output logic [XLEN-1:0]    mem_addr,
  output logic [XLEN-1:0]    mem_wdata,
  input  logic [XLEN-1:0]    mem_rdata,
  input  logic               mem_ready,
  output logic               nest_set,
  output logic               nest_clr,
  output logic               busy,
  output logic               vec_fetch,
  output logic               jump_valid,
  output logic [XLEN-1:0]    jump_target,
  output logic               nmi_unrec
);

  localparam logic [XLEN-1:0] WORD_BYTES = XLEN'(XLEN / 8);

  seq_state_e      state_q, state_d;
  logic [4:0]      idx_q, idx_d;
  logic [4:0]      cnt_q, cnt_d;
  logic [XLEN-1:0] base_q, base_d;
  logic [XLEN-1:0] hold_q, hold_d;
  logic            nmi_q, nmi_d;
  logic            accept_entry;
  logic            last_slot;
  logic [XLEN-1:0] frame_bytes;
  logic [XLEN-1:0] slot_off;

  assign accept_entry = irq_req && (depth < DEPTH_W'(NEST_LEVELS));
  assign map_trim     = accept_entry ? (depth == DEPTH_W'(NEST_LEVELS - 1))
                                     : (depth == DEPTH_W'(NEST_LEVELS));
  assign frame_bytes  = XLEN'(frame_words) * WORD_BYTES;
  assign slot_off     = (XLEN'(idx_q) + 1'b1) * WORD_BYTES;
  assign last_slot    = (idx_q == cnt_q - 5'd1);
  assign slot_idx     = idx_q;
  assign mem_addr     = base_q - slot_off;
  assign jump_target  = hold_q;
  assign nmi_unrec    = nmi_q;
  assign busy         = (state_q != ST_IDLE);

  always_comb begin
    state_d    = state_q;
    idx_d      = idx_q;
    cnt_d      = cnt_q;
    base_d     = base_q;
    hold_d     = hold_q;
    nmi_d      = 1'b0;
    rf_raddr   = REG_SP;
    rf_we      = 1'b0;
    rf_waddr   = REG_SP;
    rf_wdata   = '0;
    mem_req    = 1'b0;
    mem_we     = 1'b0;
    mem_wdata  = '0;
    nest_set   = 1'b0;
    nest_clr   = 1'b0;
    vec_fetch  = 1'b0;
    jump_valid = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (accept_entry) begin
          state_d = ST_E_SP;
          hold_d  = irq_pc;
          cnt_d   = slot_count;
          idx_d   = '0;
        end else if (ret_req) begin
          if (depth == '0) begin
            nmi_d = 1'b1;
          end else begin
            state_d = ST_X_SP;
            hold_d  = ret_target;
            cnt_d   = slot_count;
            idx_d   = '0;
          end
        end
      end
      ST_E_SP: begin
        base_d  = rf_rdata;
        state_d = ST_E_ST;
      end
      ST_E_ST: begin
        rf_raddr  = slot_reg;
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_wdata = slot_rsvd ? '0 : rf_rdata;
        if (mem_ready) begin
          if (last_slot) state_d = ST_E_SPW;
          else           idx_d   = idx_q + 5'd1;
        end
      end
      ST_E_SPW: begin
        rf_we    = 1'b1;
        rf_waddr = REG_SP;
        rf_wdata = base_q - frame_bytes;
        state_d  = ST_E_RA;
      end
      ST_E_RA: begin
        rf_we    = 1'b1;
        rf_waddr = REG_RA;
        rf_wdata = hold_q | XLEN'(1);
        state_d  = ST_E_VEC;
      end
      ST_E_VEC: begin
        vec_fetch = 1'b1;
        nest_set  = 1'b1;
        state_d   = ST_IDLE;
      end
      ST_X_SP: begin
        base_d  = rf_rdata + frame_bytes;
        state_d = ST_X_LD;
      end
      ST_X_LD: begin
        mem_req = 1'b1;
        if (mem_ready) begin
          rf_we    = !slot_rsvd;
          rf_waddr = slot_reg;
          rf_wdata = mem_rdata;
          if (last_slot) state_d = ST_X_SPW;
          else           idx_d   = idx_q + 5'd1;
        end
      end
      ST_X_SPW: begin
        rf_we    = 1'b1;
        rf_waddr = REG_SP;
        rf_wdata = base_q;
        state_d  = ST_X_DONE;
      end
      ST_X_DONE: begin
        jump_valid = 1'b1;
        nest_clr   = 1'b1;
        state_d    = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
      base_q  <= '0;
      hold_q  <= '0;
      nmi_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      cnt_q   <= cnt_d;
      base_q  <= base_d;
      hold_q  <= hold_d;
      nmi_q   <= nmi_d;
    end
  end

  // R2: a pending access is held unchanged until it completes
  a_r2_hold_until_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R5: the latched slot count never exceeds the frame
  a_r5_count_within_frame: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt_q <= frame_words));

  // R7: the vector fetch follows the return-address write
  a_r7_vec_after_ra: assert property (@(posedge clk) disable iff (!rst_n)
    vec_fetch |-> $past(rf_we && (rf_waddr == REG_RA)));

  // R10: the unrecoverable-return request is raised only while idle
  a_r10_nmi_while_idle: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_unrec |-> (!busy && !mem_req));

endmodule

// File: rtl/irq_stack_seq.sv
module irq_stack_seq #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned NUM_RANGES = 3,
  parameter int unsigned NEST_LEVELS = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   irq_req,
  input  logic [XLEN-1:0]        irq_pc,
  input  logic                   ret_req,
  input  logic [XLEN-1:0]        ret_target,
  input  logic [1:0]             lvl4_ranges,
  output logic [4:0]             rf_raddr,
  input  logic [XLEN-1:0]        rf_rdata,
  output logic                   rf_we,
  output logic [4:0]             rf_waddr,
  output logic [XLEN-1:0]        rf_wdata,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [XLEN-1:0]        mem_addr,
  output logic [XLEN-1:0]        mem_wdata,
  input  logic [XLEN-1:0]        mem_rdata,
  input  logic                   mem_ready,
  output logic                   busy,
  output logic [NEST_LEVELS-1:0] nest_status,
  output logic                   vec_fetch,
  output logic                   jump_valid,
  output logic [XLEN-1:0]        jump_target,
  output logic                   nmi_unrec
);

  localparam int unsigned DEPTH_W = $clog2(NEST_LEVELS + 1);

  logic [DEPTH_W-1:0] depth;
  logic [4:0]         slot_idx;
  logic [4:0]         slot_reg;
  logic               slot_rsvd;
  logic [4:0]         slot_count;
  logic [4:0]         frame_words;
  logic               map_trim;
  logic               nest_set;
  logic               nest_clr;

  irq_slot_map #(
    .NUM_RANGES (NUM_RANGES)
  ) u_map (
    .slot_idx    (slot_idx),
    .trim        (map_trim),
    .lvl4_ranges (lvl4_ranges),
    .slot_reg    (slot_reg),
    .slot_rsvd   (slot_rsvd),
    .slot_count  (slot_count),
    .frame_words (frame_words)
  );

  irq_nest_tracker #(
    .NEST_LEVELS (NEST_LEVELS)
  ) u_nest (
    .clk      (clk),
    .rst_n    (rst_n),
    .nest_set (nest_set),
    .nest_clr (nest_clr),
    .status   (nest_status),
    .depth    (depth)
  );

  irq_stack_fsm #(
    .XLEN        (XLEN),
    .NEST_LEVELS (NEST_LEVELS)
  ) u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .irq_req     (irq_req),
    .irq_pc      (irq_pc),
    .ret_req     (ret_req),
    .ret_target  (ret_target),
    .depth       (depth),
    .slot_reg    (slot_reg),
    .slot_rsvd   (slot_rsvd),
    .slot_count  (slot_count),
    .frame_words (frame_words),
    .map_trim    (map_trim),
    .slot_idx    (slot_idx),
    .rf_raddr    (rf_raddr),
    .rf_rdata    (rf_rdata),
    .rf_we       (rf_we),
    .rf_waddr    (rf_waddr),
    .rf_wdata    (rf_wdata),
    .mem_req     (mem_req),
    .mem_we      (mem_we),
    .mem_addr    (mem_addr),
    .mem_wdata   (mem_wdata),
    .mem_rdata   (mem_rdata),
    .mem_ready   (mem_ready),
    .nest_set    (nest_set),
    .nest_clr    (nest_clr),
    .busy        (busy),
    .vec_fetch   (vec_fetch),
    .jump_valid  (jump_valid),
    .jump_target (jump_target),
    .nmi_unrec   (nmi_unrec)
  );

endmodule

// File: tb/irq_stack_seq_bench.sv
module irq_stack_seq_bench;

  logic        clk;
  logic        rst_n;
  logic        irq_req;
  logic [31:0] irq_pc;
  logic        ret_req;
  logic [31:0] ret_target;
  logic [1:0]  lvl4_ranges;
  logic [4:0]  rf_raddr;
  logic [31:0] rf_rdata;
  logic        rf_we;
  logic [4:0]  rf_waddr;
  logic [31:0] rf_wdata;
  logic        mem_req;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata;
  logic        mem_ready;
  logic        busy;
  logic [3:0]  nest_status;
  logic        vec_fetch;
  logic        jump_valid;
  logic [31:0] jump_target;
  logic        nmi_unrec;

  irq_stack_seq u_irq_stack_seq (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_pc(irq_pc),
    .ret_req(ret_req), .ret_target(ret_target), .lvl4_ranges(lvl4_ranges),
    .rf_raddr(rf_raddr), .rf_rdata(rf_rdata), .rf_we(rf_we),
    .rf_waddr(rf_waddr), .rf_wdata(rf_wdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ready(mem_ready), .busy(busy),
    .nest_status(nest_status), .vec_fetch(vec_fetch),
    .jump_valid(jump_valid), .jump_target(jump_target), .nmi_unrec(nmi_unrec)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int errors = 0;
  int checks = 0;

  // register file and memory models
  logic [31:0] rf [0:31];
  logic [31:0] mem [0:1023];
  int          mem_delay = 0;
  int          wcnt = 0;
  logic [31:0] st_addr [0:31];
  logic [31:0] st_data [0:31];
  int st_n = 0, ld_n = 0, rfw_n = 0, vec_n = 0, jump_n = 0, nmi_n = 0, busy_n = 0;
  logic [31:0] last_jump = 0;

  assign rf_rdata  = rf[rf_raddr];
  assign mem_rdata = mem[mem_addr[11:2]];
  assign mem_ready = mem_req && (wcnt == mem_delay);

  always @(posedge clk) begin
    if (mem_req && !mem_ready) wcnt <= wcnt + 1;
    else                       wcnt <= 0;
    if (mem_req && mem_ready) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] <= mem_wdata;
        if (st_n < 32) begin
          st_addr[st_n] <= mem_addr;
          st_data[st_n] <= mem_wdata;
        end
        st_n <= st_n + 1;
      end else begin
        ld_n <= ld_n + 1;
      end
    end
    if (rf_we) begin
      if (rf_waddr != 5'd0) rf[rf_waddr] <= rf_wdata;
      rfw_n <= rfw_n + 1;
    end
    if (vec_fetch) vec_n <= vec_n + 1;
    if (jump_valid) begin
      jump_n    <= jump_n + 1;
      last_jump <= jump_target;
    end
    if (nmi_unrec) nmi_n <= nmi_n + 1;
    if (busy) busy_n <= busy_n + 1;
  end

  // expected slot order from R2
  function automatic int exp_reg(input int k);
    case (k)
      0: return 1;   1: return 10;  2: return 11;  3: return 0;
      4: return 12;  5: return 13;  6: return 14;  7: return 15;
      8: return 4;   9: return 5;   10: return 6;  11: return 7;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic clear_counts();
    @(negedge clk);
    st_n = 0; ld_n = 0; rfw_n = 0; vec_n = 0; jump_n = 0; nmi_n = 0; busy_n = 0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 1000 && busy; i++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic do_enter(input logic [31:0] pc, input bit hold);
    @(negedge clk);
    irq_req = 1'b1;
    irq_pc  = pc;
    @(negedge clk);
    if (hold) begin
      for (int i = 0; i < 1000 && !vec_fetch; i++) @(negedge clk);
    end
    irq_req = 1'b0;
    wait_idle();
  endtask

  task automatic do_exit(input logic [31:0] tgt);
    @(negedge clk);
    ret_req    = 1'b1;
    ret_target = tgt;
    @(negedge clk);
    ret_req = 1'b0;
    wait_idle();
  endtask

  task automatic t_reset();
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 nest_status", {28'd0, nest_status}, 32'd0);
    chk("R1 mem_req/rf_we", {30'd0, mem_req, rf_we}, 32'd0);
  endtask

  task automatic t_entry_basic();
    for (int i = 1; i < 32; i++) rf[i] = 32'h1000 + i;
    rf[2] = 32'h800;
    mem[(32'h800 - 16) >> 2] = 32'hDEADBEEF;
    clear_counts();
    do_enter(32'h2000_0100, 1'b1);
    chk("R4 store count lvl1", st_n, 12);
    for (int k = 0; k < 12; k++) begin
      chk("R2 store address", st_addr[k], 32'h800 - 4 * (k + 1));
      if (k == 3) chk("R3 reserved slot data", st_data[k], 32'h0);
      else        chk("R2 store data", st_data[k], 32'h1000 + exp_reg(k));
    end
    chk("R3 reserved word in memory", mem[(32'h800 - 16) >> 2], 32'h0);
    chk("R6 sp lowered", rf[2], 32'h7D0);
    chk("R7 ra value", rf[1], 32'h2000_0101);
    chk("R7 status lvl1", {28'd0, nest_status}, 32'h1);
    chk("R7 vec_fetch pulses", vec_n, 1);
  endtask

  task automatic t_exit_basic();
    for (int k = 0; k < 12; k++)
      if (exp_reg(k) != 0) rf[exp_reg(k)] = 32'hBAD0_0000 | exp_reg(k);
    clear_counts();
    do_exit(32'h3000);
    chk("R8 load count", ld_n, 12);
    chk("R3 reserved not written back (rf writes)", rfw_n, 12);
    for (int k = 0; k < 12; k++)
      if (exp_reg(k) != 0)
        chk("R8 restored register", rf[exp_reg(k)], 32'h1000 + exp_reg(k));
    chk("R6 sp raised", rf[2], 32'h800);
    chk("R8 status cleared", {28'd0, nest_status}, 32'h0);
    chk("R8 jump pulses", jump_n, 1);
    chk("R8 jump target", last_jump, 32'h3000);
  endtask

  task automatic t_wait_states();
    mem_delay = 2;
    clear_counts();
    do_enter(32'h4000, 1'b1);
    chk("R2 stores with wait states", st_n, 12);
    chk("R2 busy cycles entry", busy_n, 40);
    clear_counts();
    do_exit(32'h4444);
    chk("R2 busy cycles exit", busy_n, 39);
    chk("R8 restore with wait states", rf[1], 32'h1001);
    mem_delay = 0;
  endtask

  task automatic t_nest4();
    lvl4_ranges = 2'b00;
    do_enter(32'h5100, 1'b1);
    do_enter(32'h5200, 1'b1);
    do_enter(32'h5300, 1'b1);
    chk("R6 sp after three levels", rf[2], 32'h770);
    clear_counts();
    do_enter(32'h5400, 1'b1);
    chk("R5 lvl4 sel 00 stores", st_n, 4);
    chk("R6 lvl4 sp full frame", rf[2], 32'h740);
    chk("R7 status four levels", {28'd0, nest_status}, 32'hF);
    // R11: request with all levels active
    clear_counts();
    irq_req = 1'b1;
    irq_pc  = 32'h5500;
    repeat (3) @(negedge clk);
    irq_req = 1'b0;
    @(negedge clk);
    chk("R11 ignored when full (busy)", busy_n, 0);
    chk("R11 ignored when full (stores)", st_n, 0);
    chk("R11 status unchanged", {28'd0, nest_status}, 32'hF);
    rf[10] = 32'h55;
    rf[12] = 32'h66;
    clear_counts();
    do_exit(32'h6000);
    chk("R5 lvl4 trimmed loads", ld_n, 4);
    chk("R5 x10 restored", rf[10], 32'h100A);
    chk("R5 x12 untouched by return", rf[12], 32'h66);
    chk("R8 ra restored to level3 pc", rf[1], 32'h5301);
    chk("R6 sp raised full frame", rf[2], 32'h770);
    chk("R8 status three levels", {28'd0, nest_status}, 32'h7);
    lvl4_ranges = 2'b11;
    clear_counts();
    do_enter(32'h5600, 1'b1);
    chk("R5 sel 11 clamped stores", st_n, 12);
    do_exit(32'h6100);
    lvl4_ranges = 2'b01;
    clear_counts();
    do_enter(32'h5700, 1'b1);
    chk("R5 sel 01 stores", st_n, 8);
    do_exit(32'h6200);
    chk("R6 sp back at level3", rf[2], 32'h770);
  endtask

  task automatic t_spurious();
    do_exit(32'h7000);
    do_exit(32'h7100);
    do_exit(32'h7200);
    chk("R8 all levels unwound", {28'd0, nest_status}, 32'h0);
    clear_counts();
    do_enter(32'h8000, 1'b0);
    chk("R9 entry completes stores", st_n, 12);
    chk("R9 status set", {28'd0, nest_status}, 32'h1);
    chk("R9 vec_fetch issued", vec_n, 1);
    chk("R9 ra written", rf[1], 32'h8001);
    do_exit(32'h8100);
  endtask

  task automatic t_nmi();
    clear_counts();
    do_exit(32'h9000);
    chk("R10 nmi pulse", nmi_n, 1);
    chk("R10 no memory access", st_n + ld_n, 0);
    chk("R10 no register write", rfw_n, 0);
    chk("R10 no jump", jump_n, 0);
    chk("R10 sp unchanged", rf[2], 32'h800);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    irq_req = 1'b0;
    irq_pc = '0;
    ret_req = 1'b0;
    ret_target = '0;
    lvl4_ranges = 2'b10;
    for (int i = 0; i < 32; i++) rf[i] = '0;
    for (int i = 0; i < 1024; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_entry_basic();
    t_exit_basic();
    t_wait_states();
    t_nest4();
    t_spurious();
    t_nmi();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule